// File: doc/BRIEF.md
# Redundant binary signed-digit adder

This block adds two N-digit radix-2 operands whose digits may each be -1, 0 or +1. The result has N+1 digits in the same form. The circuit is purely combinational, and its depth does not grow with N, because no carry travels more than one position.

Each digit is carried on a pair of wires (p, n), and its value is p - n. The adder works in two steps. In the first step, every position looks at its own two operand digits and at the signs of the two digits one position lower. From these it forms a local sum digit and a transfer digit toward the next higher position. In the second step, every position adds its local sum digit to the transfer arriving from below. The first step is chosen so that this second addition always lands inside {-1, 0, +1}.

The block is intended as the inner adder of wide multipliers or accumulators that keep values in redundant form. A separate converter turns the result into two's-complement form only when that form is needed.

Top module: `rbsd_adder`

## Requirements
- R1: The digit at position i has the value p[i] - n[i], and the operand value is the sum of digit × 2^i. An input pair (p=1, n=1) is worth 0 and gives exactly the same result as (0, 0).
- R2: The value of the (N+1)-digit result always equals the value of x plus the value of y. This holds for every legal digit pattern of either operand.
- R3: No result digit is ever driven as (p=1, n=1).
- R4: Result digit i depends only on operand digits i, i-1 and i-2. Changing an operand digit at position j leaves every result digit below j unchanged, and every result digit above j+2 unchanged.
- R5: Result digit N is the transfer out of position N-1, and the sum never overflows. With both operands at +1 in digit N-1 and 0 elsewhere, the result is +1 at digit N and 0 elsewhere. With both at -1, the result is -1 at digit N and 0 elsewhere.
- R6: Take a position whose operand digits sum to +1 while both digits one position lower are non-negative (position 0 always counts as having a non-negative neighbour below). That position sends transfer +1 and keeps -1. So x = +1 at digit 0 plus y = 0 gives the result +1 at digit 1 and -1 at digit 0.
- R7: Take a position whose operand digits sum to +1 while a digit one position lower is negative. That position sends transfer 0 and keeps +1. So x = (+1 at digit 1, -1 at digit 0) plus y = 0 gives back exactly that pattern.
- R8: Different digit patterns of the same value are all accepted. Six written as (+1 0 -1 0) and six written as (0 +1 +1 0) each add correctly to any other operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_p | input | N | Positive rails of operand x digits |
| x_n | input | N | Negative rails of operand x digits |
| y_p | input | N | Positive rails of operand y digits |
| y_n | input | N | Negative rails of operand y digits |
| z_p | output | N+1 | Positive rails of the sum digits |
| z_n | output | N+1 | Negative rails of the sum digits |

## Verification
The transfer selection from the lower neighbour's sign and the second-step absorption of the incoming transfer act in the same evaluation at one position. The case that matters is a transfer arriving at a position that itself holds a non-zero local sum digit. The bench provokes this by sweeping every digit combination of the low three positions, and by random operands that are dense in ±1 digits. It judges each result by its integer value, by the absence of (1,1) digits, and by the locality of a single-digit change.

// File: rtl/rbsd_adder.sv
module rbsd_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] x_p,
  input  logic [N-1:0] x_n,
  input  logic [N-1:0] y_p,
  input  logic [N-1:0] y_n,
  output logic [N:0]   z_p,
  output logic [N:0]   z_n
);
  logic [N-1:0] xp, xn, yp, yn;
  logic [N-1:0] t_p, t_n, w_p, w_n;

  assign xp = x_p & ~x_n;
  assign xn = x_n & ~x_p;
  assign yp = y_p & ~y_n;
  assign yn = y_n & ~y_p;

  for (genvar i = 0; i < N; i++) begin : g_dig
    logic two_p, two_n, one_p, one_n, nb, cin_p, cin_n;
    assign two_p = xp[i] & yp[i];
    assign two_n = xn[i] & yn[i];
    assign one_p = (xp[i] & ~yp[i] & ~yn[i]) | (yp[i] & ~xp[i] & ~xn[i]);
    assign one_n = (xn[i] & ~yp[i] & ~yn[i]) | (yn[i] & ~xp[i] & ~xn[i]);
    if (i == 0) begin : g_lo
      assign nb    = 1'b1;
      assign cin_p = 1'b0;
      assign cin_n = 1'b0;
    end else begin : g_hi
      assign nb    = ~(xn[i-1] | yn[i-1]);
      assign cin_p = t_p[i-1];
      assign cin_n = t_n[i-1];
    end
    assign t_p[i] = two_p | (one_p & nb);
    assign t_n[i] = two_n | (one_n & ~nb);
    assign w_p[i] = (one_p | one_n) & ~nb;
    assign w_n[i] = (one_p | one_n) & nb;
    assign z_p[i] = (w_p[i] & ~cin_n) | (cin_p & ~w_n[i]);
    assign z_n[i] = (w_n[i] & ~cin_p) | (cin_n & ~w_p[i]);
  end

  assign z_p[N] = t_p[N-1];
  assign z_n[N] = t_n[N-1];
endmodule

// File: rtl/rbsd_adder_chk.sv
module rbsd_adder_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] x_p,
  input logic [N-1:0] x_n,
  input logic [N-1:0] y_p,
  input logic [N-1:0] y_n,
  input logic [N:0]   z_p,
  input logic [N:0]   z_n
);
  function automatic longint sd_value(input logic [N:0] p, input logic [N:0] n);
    longint acc = 0;
    for (int i = 0; i <= N; i++)
      acc += (longint'(p[i]) - longint'(n[i])) <<< i;
    return acc;
  endfunction

  longint vx, vy, vz;

  always_comb begin
    vx = sd_value({1'b0, x_p}, {1'b0, x_n});
    vy = sd_value({1'b0, y_p}, {1'b0, y_n});
    vz = sd_value(z_p, z_n);
    p_sum_value_r2: assert (vz == vx + vy)
      else $error("sum value %0d, operands %0d + %0d", vz, vx, vy);
    p_no_both_rails_r3: assert ((z_p & z_n) == '0)
      else $error("illegal result digit %b %b", z_p, z_n);
    p_top_sign_r5: assert ((!z_p[N] || vz > 0) && (!z_n[N] || vz < 0))
      else $error("top digit disagrees with sign of %0d", vz);
    p_zero_sum_r2: assert (!(vx == 0 && vy == 0) || ((z_p | z_n) == '0))
      else $error("zero operands gave non-zero digits");
    p_lsb_parity_r4: assert ((z_p[0] | z_n[0]) == ((x_p[0] ^ x_n[0]) ^ (y_p[0] ^ y_n[0])))
      else $error("digit 0 parity mismatch");
  end
endmodule

bind rbsd_adder rbsd_adder_chk #(.N(N)) u_chk (.*);

// File: tb/tb_rbsd_adder.sv
module tb_rbsd_adder;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic [N-1:0] x_p, x_n, y_p, y_n;
  logic [N:0]   z_p, z_n;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rbsd_adder #(.N(N)) dut (.*);

  function automatic longint val(input logic [N:0] p, input logic [N:0] n);
    longint acc = 0;
    for (int i = 0; i <= N; i++)
      acc += (longint'(p[i]) - longint'(n[i])) <<< i;
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] ap, an, bp, bn);
    @(posedge clk);
    x_p = ap; x_n = an; y_p = bp; y_n = bn;
    @(negedge clk);
  endtask

  task automatic check_sum(input string req);
    longint e = val({1'b0, x_p}, {1'b0, x_n}) + val({1'b0, y_p}, {1'b0, y_n});
    check(val(z_p, z_n) == e, req, "value", val(z_p, z_n), e);
    check((z_p & z_n) == '0, "R3", "both rails", longint'(z_p & z_n), 0);
  endtask

  function automatic logic [1:0] rnd_digit();
    int r = $urandom_range(2);
    return (r == 0) ? 2'b00 : (r == 1) ? 2'b10 : 2'b01;
  endfunction

  task automatic t_zero();
    apply('0, '0, '0, '0);
    check(z_p == '0 && z_n == '0, "R2", "zero in zero out", longint'({z_p, z_n}), 0);
  endtask

  task automatic t_top();
    apply(N'(1) << (N-1), '0, N'(1) << (N-1), '0);
    check(z_p == (N+1)'(1) << N && z_n == '0, "R5", "top +1", longint'({z_p, z_n}), longint'((N+1)'(1) << N) << (N+1));
    apply('0, N'(1) << (N-1), '0, N'(1) << (N-1));
    check(z_n == (N+1)'(1) << N && z_p == '0, "R5", "top -1", longint'({z_p, z_n}), longint'((N+1)'(1) << N));
    apply('1, '0, '1, '0);
    check_sum("R5");
  endtask

  task automatic t_rules();
    apply(N'(1), '0, '0, '0);
    check(z_p == (N+1)'(2) && z_n == (N+1)'(1), "R6", "+1 with non-negative below",
          longint'({z_p, z_n}), longint'({(N+1)'(2), (N+1)'(1)}));
    apply(N'(2), N'(1), '0, '0);
    check(z_p == (N+1)'(2) && z_n == (N+1)'(1), "R7", "+1 with negative below",
          longint'({z_p, z_n}), longint'({(N+1)'(2), (N+1)'(1)}));
  endtask

  task automatic t_both_rails();
    logic [N:0] rp, rn;
    apply(8'b0010_0110, 8'b0000_0001, 8'b0100_0001, 8'b0000_1000);
    rp = z_p; rn = z_n;
    apply(8'b0010_1110, 8'b0000_1001, 8'b0100_0001, 8'b0000_1000);
    check(z_p == rp && z_n == rn, "R1", "(1,1) digit acts as 0", longint'({z_p, z_n}), longint'({rp, rn}));
    check_sum("R1");
  endtask

  task automatic t_alt_forms();
    apply(8'b0000_1000, 8'b0000_0010, 8'b0000_0110, '0);
    check(val(z_p, z_n) == 12, "R8", "6 + 6 two forms", val(z_p, z_n), 12);
    apply(8'b0000_1000, 8'b0000_0010, 8'b0000_0000, 8'b0000_0110);
    check(val(z_p, z_n) == 0, "R8", "6 - 6 two forms", val(z_p, z_n), 0);
  endtask

  task automatic t_exhaustive_low();
    for (int a = 0; a < 729; a++) begin
      logic [N-1:0] ap = '0, an = '0, bp = '0, bn = '0;
      int r = a;
      for (int k = 0; k < 6; k++) begin
        int d = r % 3;
        r = r / 3;
        if (k < 3) begin ap[k] = (d == 1); an[k] = (d == 2); end
        else begin bp[k-3] = (d == 1); bn[k-3] = (d == 2); end
      end
      apply(ap, an, bp, bn);
      check_sum("R2");
    end
  endtask

  task automatic t_random();
    for (int t = 0; t < 1500; t++) begin
      logic [N-1:0] ap, an, bp, bn;
      for (int k = 0; k < N; k++) begin
        {ap[k], an[k]} = rnd_digit();
        {bp[k], bn[k]} = rnd_digit();
      end
      apply(ap, an, bp, bn);
      check_sum("R2");
    end
  endtask

  task automatic t_locality();
    for (int t = 0; t < 200; t++) begin
      logic [N-1:0] ap, an, bp, bn;
      logic [N:0] rp, rn, keep;
      int j = $urandom_range(N-1);
      for (int k = 0; k < N; k++) begin
        {ap[k], an[k]} = rnd_digit();
        {bp[k], bn[k]} = rnd_digit();
      end
      apply(ap, an, bp, bn);
      rp = z_p; rn = z_n;
      if (ap[j]) begin ap[j] = 1'b0; an[j] = 1'b1; end
      else if (an[j]) an[j] = 1'b0;
      else ap[j] = 1'b1;
      apply(ap, an, bp, bn);
      keep = '0;
      for (int k = 0; k <= N; k++) keep[k] = (k < j) || (k > j + 2);
      check(((z_p ^ rp) & keep) == '0 && ((z_n ^ rn) & keep) == '0, "R4", "locality",
            longint'({z_p, z_n}), longint'({rp, rn}));
    end
  endtask

  initial begin
    x_p = '0; x_n = '0; y_p = '0; y_n = '0;
    t_zero();
    t_top();
    t_rules();
    t_both_rails();
    t_alt_forms();
    t_exhaustive_low();
    t_random();
    t_locality();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule